// File: doc/BRIEF.md
# Flash Array Controller with Erase Sequencer

This block sits in front of a small on-chip flash model made of two RAM regions: a main array split into equal pages and a separate, smaller configuration region. A narrow register bus holds a two-bit mode field, a status word whose ready bit is always set, two page-erase address registers and two whole-region wipe triggers. A second port gives word access to both regions. A write on that port is stored only while the mode permits programming. Erase requests act only while the mode permits erasing.

An erase is not instantaneous. A sequencer writes all-ones into the target region one word per clock cycle. While it runs, the array port lowers its ready signal, so a pending array access waits and then completes against the erased contents. The register bus is never stalled, and its status bit keeps reporting ready.

Top module: `flash_ctrl`

## Requirements
- R1: The mode field occupies bits [1:0] of the register at word index 0. It resets to 0 and reads back the last value written, including 3. Bits [31:2] read as zero.
- R2: Bit 0 of the register at word index 1 always reads as 1, even while an erase is running.
- R3: In mode 1, a write on the array port to a main-array byte address (below the main size) or to a configuration address (from the configuration base up to base plus its size) stores the word. A later read returns that word, with `mem_rvalid` high in the cycle after the read is accepted.
- R4: Array-port writes made in mode 0, 2 or 3 leave the array unchanged.
- R5: In mode 2, writing a byte address below the main size to either page-erase register (word index 2 or 3) sets every word of the page holding that address to 0xFFFFFFFF. Neighbouring pages keep their contents, and addresses at or past the main size are ignored.
- R6: In mode 2, writing a value with bit 0 set to the register at word index 4 sets every main-array word to 0xFFFFFFFF.
- R7: In mode 2, writing a value with bit 0 set to the register at word index 5 sets every configuration word to 0xFFFFFFFF and leaves the main array unchanged.
- R8: Erase-register writes have no effect in any mode other than 2, when bit 0 is clear for the wipe triggers, or while an erase is already running.
- R9: An erase covering N words holds `mem_ready` low for exactly N cycles after the trigger cycle. An array access presented in that window completes once the erase is done.
- R10: Array-port reads outside both regions return zero, and writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | Register write when high |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | input | 1 | Array access request |
| mem_we | input | 1 | Array write when high |
| mem_addr | input | ADDR_W | Array byte address |
| mem_wdata | input | 32 | Array write data |
| mem_ready | output | 1 | Array access accepted this cycle when high |
| mem_rvalid | output | 1 | Read data valid, one cycle after acceptance |
| mem_rdata | output | 32 | Array read data |

## Verification
The bench erases one page, then scans the pages on both sides of it. A sequencer whose start or end index is off by one would damage a neighbour or leave a stale word at the page edge. It counts the exact number of stalled cycles for page, main and configuration erases; a wrong length or a port that is never stalled shows up as a count mismatch or as pre-erase data. It issues erase triggers in the wrong mode, with bit 0 clear, and while an erase is running; a design that acted on them would wipe data the bench still expects. Random traffic mixes mode changes, writes, erases and reads, including addresses outside both regions.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_PROG  = 2'd1,
        MODE_ERASE = 2'd2,
        MODE_RSVD  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ERQ_NONE = 2'd0,
        ERQ_PAGE = 2'd1,
        ERQ_MAIN = 2'd2,
        ERQ_CFG  = 2'd3
    } erq_e;

    localparam int REG_IDX_W = 3;

    localparam logic [REG_IDX_W-1:0] RIDX_CTRL      = 3'd0;
    localparam logic [REG_IDX_W-1:0] RIDX_STATUS    = 3'd1;
    localparam logic [REG_IDX_W-1:0] RIDX_PGERASE_A = 3'd2;
    localparam logic [REG_IDX_W-1:0] RIDX_PGERASE_B = 3'd3;
    localparam logic [REG_IDX_W-1:0] RIDX_WIPE_MAIN = 3'd4;
    localparam logic [REG_IDX_W-1:0] RIDX_WIPE_CFG  = 3'd5;

    localparam logic [31:0] ERASED_WORD = 32'hFFFF_FFFF;

endpackage

// File: rtl/flash_ctrl_regs.sv
module flash_ctrl_regs
    import flash_ctrl_pkg::*;
#(
    parameter int MAIN_BYTES = 512,
    parameter int PAGE_BYTES = 64,
    parameter int PAGE_IDX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_req,
    input  logic                  reg_we,
    input  logic [REG_IDX_W-1:0]  reg_addr,
    input  logic [31:0]           reg_wdata,
    input  logic                  eng_busy,
    output logic [31:0]           reg_rdata,
    output mode_e                 mode,
    output erq_e                  erq_kind,
    output logic [PAGE_IDX_W-1:0] erq_page
);

    localparam int PG_SHIFT = $clog2(PAGE_BYTES);

    typedef struct packed {
        mode_e mode;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr;
    logic  erase_ok;
    logic  addr_in_main;

    always_comb begin
        st_d         = st_q;
        erq_kind     = ERQ_NONE;
        erq_page     = reg_wdata[PG_SHIFT +: PAGE_IDX_W];
        wr           = reg_req && reg_we;
        erase_ok     = (st_q.mode == MODE_ERASE) && !eng_busy;
        addr_in_main = reg_wdata < 32'(MAIN_BYTES);

        if (wr) begin
            case (reg_addr)
                RIDX_CTRL: st_d.mode = mode_e'(reg_wdata[1:0]);
                RIDX_PGERASE_A,
                RIDX_PGERASE_B: begin
                    if (erase_ok && addr_in_main) erq_kind = ERQ_PAGE;
                end
                RIDX_WIPE_MAIN: begin
                    if (erase_ok && reg_wdata[0]) erq_kind = ERQ_MAIN;
                end
                RIDX_WIPE_CFG: begin
                    if (erase_ok && reg_wdata[0]) erq_kind = ERQ_CFG;
                end
                default: ;
            endcase
        end

        case (reg_addr)
            RIDX_CTRL:   reg_rdata = {30'd0, st_q.mode};
            RIDX_STATUS: reg_rdata = 32'd1;
            default:     reg_rdata = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: MODE_READ};
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;

endmodule

// File: rtl/flash_ctrl_erase.sv
module flash_ctrl_erase
    import flash_ctrl_pkg::*;
#(
    parameter int PAGE_WORDS = 16,
    parameter int MAIN_WORDS = 128,
    parameter int CFG_WORDS  = 32,
    parameter int PAGE_IDX_W = 3,
    parameter int IDX_W      = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  erq_e                  erq_kind,
    input  logic [PAGE_IDX_W-1:0] erq_page,
    output logic                  busy,
    output logic                  wipe_we,
    output logic                  wipe_cfg,
    output logic [IDX_W-1:0]      wipe_idx
);

    localparam int PW_LOG2 = $clog2(PAGE_WORDS);

    typedef struct packed {
        logic             active;
        logic             cfg;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
    } seq_t;

    seq_t             st_d, st_q;
    logic [IDX_W-1:0] page_first;

    always_comb begin
        st_d       = st_q;
        page_first = IDX_W'(erq_page) << PW_LOG2;

        if (st_q.active) begin
            if (st_q.idx == st_q.last) st_d.active = 1'b0;
            else                       st_d.idx    = st_q.idx + 1'b1;
        end else begin
            case (erq_kind)
                ERQ_PAGE: begin
                    st_d.active = 1'b1;
                    st_d.cfg    = 1'b0;
                    st_d.idx    = page_first;
                    st_d.last   = page_first + IDX_W'(PAGE_WORDS - 1);
                end
                ERQ_MAIN: begin
                    st_d.active = 1'b1;
                    st_d.cfg    = 1'b0;
                    st_d.idx    = '0;
                    st_d.last   = IDX_W'(MAIN_WORDS - 1);
                end
                ERQ_CFG: begin
                    st_d.active = 1'b1;
                    st_d.cfg    = 1'b1;
                    st_d.idx    = '0;
                    st_d.last   = IDX_W'(CFG_WORDS - 1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.active;
    assign wipe_we  = st_q.active;
    assign wipe_cfg = st_q.cfg;
    assign wipe_idx = st_q.idx;

endmodule

// File: rtl/flash_ctrl_store.sv
module flash_ctrl_store #(
    parameter int MAIN_WORDS = 128,
    parameter int CFG_WORDS  = 32,
    parameter int IDX_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             wcfg,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic             re,
    input  logic             rhit,
    input  logic             rcfg,
    input  logic [IDX_W-1:0] ridx,
    output logic             rvalid,
    output logic [31:0]      rdata
);

    localparam int MIDX_W = $clog2(MAIN_WORDS);
    localparam int CIDX_W = $clog2(CFG_WORDS);

    typedef struct packed {
        logic        rvalid;
        logic [31:0] rdata;
    } rd_t;

    logic [31:0] main_mem [MAIN_WORDS];
    logic [31:0] cfg_mem  [CFG_WORDS];
    rd_t         rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            if (wcfg) cfg_mem[widx[CIDX_W-1:0]]  <= wdata;
            else      main_mem[widx[MIDX_W-1:0]] <= wdata;
        end
    end

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = re;
        if (re) begin
            if (!rhit)     rd_d.rdata = 32'd0;
            else if (rcfg) rd_d.rdata = cfg_mem[ridx[CIDX_W-1:0]];
            else           rd_d.rdata = main_mem[ridx[MIDX_W-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rvalid = rd_q.rvalid;
    assign rdata  = rd_q.rdata;

endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
    import flash_ctrl_pkg::*;
#(
    parameter int PAGE_WORDS = 16,
    parameter int MAIN_PAGES = 8,
    parameter int CFG_WORDS  = 32,
    parameter int ADDR_W     = 16,
    parameter int CFG_BASE   = 32'h8000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_req,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 mem_req,
    input  logic                 mem_we,
    input  logic [ADDR_W-1:0]    mem_addr,
    input  logic [31:0]          mem_wdata,
    output logic                 mem_ready,
    output logic                 mem_rvalid,
    output logic [31:0]          mem_rdata
);

    localparam int MAIN_WORDS = PAGE_WORDS * MAIN_PAGES;
    localparam int MAIN_BYTES = MAIN_WORDS * 4;
    localparam int PAGE_BYTES = PAGE_WORDS * 4;
    localparam int CFG_BYTES  = CFG_WORDS * 4;
    localparam int MAX_WORDS  = (MAIN_WORDS > CFG_WORDS) ? MAIN_WORDS : CFG_WORDS;
    localparam int IDX_W      = $clog2(MAX_WORDS);
    localparam int PAGE_IDX_W = (MAIN_PAGES > 1) ? $clog2(MAIN_PAGES) : 1;

    mode_e                 mode;
    erq_e                  erq_kind;
    logic [PAGE_IDX_W-1:0] erq_page;
    logic                  busy;
    logic                  wipe_we;
    logic                  wipe_cfg;
    logic [IDX_W-1:0]      wipe_idx;

    logic                  acc;
    logic                  hit_main;
    logic                  hit_cfg;
    logic [ADDR_W-1:0]     cfg_off;
    logic [IDX_W-1:0]      bus_idx;
    logic                  bus_wr;
    logic                  st_we;
    logic                  st_wcfg;
    logic [IDX_W-1:0]      st_widx;
    logic [31:0]           st_wdata;

    flash_ctrl_regs #(
        .MAIN_BYTES (MAIN_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_IDX_W (PAGE_IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .eng_busy  (busy),
        .reg_rdata (reg_rdata),
        .mode      (mode),
        .erq_kind  (erq_kind),
        .erq_page  (erq_page)
    );

    flash_ctrl_erase #(
        .PAGE_WORDS (PAGE_WORDS),
        .MAIN_WORDS (MAIN_WORDS),
        .CFG_WORDS  (CFG_WORDS),
        .PAGE_IDX_W (PAGE_IDX_W),
        .IDX_W      (IDX_W)
    ) u_erase (
        .clk      (clk),
        .rst_n    (rst_n),
        .erq_kind (erq_kind),
        .erq_page (erq_page),
        .busy     (busy),
        .wipe_we  (wipe_we),
        .wipe_cfg (wipe_cfg),
        .wipe_idx (wipe_idx)
    );

    always_comb begin
        mem_ready = !busy;
        acc       = mem_req && mem_ready;
        hit_main  = mem_addr < ADDR_W'(MAIN_BYTES);
        hit_cfg   = (mem_addr >= ADDR_W'(CFG_BASE)) &&
                    (mem_addr <  ADDR_W'(CFG_BASE + CFG_BYTES));
        cfg_off   = mem_addr - ADDR_W'(CFG_BASE);
        bus_idx   = hit_cfg ? cfg_off[2 +: IDX_W] : mem_addr[2 +: IDX_W];
        bus_wr    = acc && mem_we && (mode == MODE_PROG) && (hit_main || hit_cfg);

        st_we     = wipe_we || bus_wr;
        st_wcfg   = wipe_we ? wipe_cfg : hit_cfg;
        st_widx   = wipe_we ? wipe_idx : bus_idx;
        st_wdata  = wipe_we ? ERASED_WORD : mem_wdata;
    end

    flash_ctrl_store #(
        .MAIN_WORDS (MAIN_WORDS),
        .CFG_WORDS  (CFG_WORDS),
        .IDX_W      (IDX_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (st_we),
        .wcfg   (st_wcfg),
        .widx   (st_widx),
        .wdata  (st_wdata),
        .re     (acc && !mem_we),
        .rhit   (hit_main || hit_cfg),
        .rcfg   (hit_cfg),
        .ridx   (bus_idx),
        .rvalid (mem_rvalid),
        .rdata  (mem_rdata)
    );

endmodule

// File: rtl/flash_ctrl_checker.sv
module flash_ctrl_checker #(
    parameter int MAIN_WORDS = 128,
    parameter int CFG_WORDS  = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_req,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ready,
    input logic        mem_rvalid
);

    localparam int MAX_WORDS = (MAIN_WORDS > CFG_WORDS) ? MAIN_WORDS : CFG_WORDS;
    localparam int CNT_W     = $clog2(MAX_WORDS + 2) + 1;

    logic [1:0]       mode_sh;
    logic [CNT_W-1:0] stall_cnt;
    logic             ctrl_wr;
    logic             rd_acc;

    assign ctrl_wr = reg_req && reg_we && (reg_addr == 3'd0);
    assign rd_acc  = mem_req && mem_ready && !mem_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_sh   <= 2'd0;
            stall_cnt <= '0;
        end else begin
            if (ctrl_wr) mode_sh <= reg_wdata[1:0];
            stall_cnt <= mem_ready ? '0 : stall_cnt + 1'b1;
        end
    end

    assert_ctrl_echo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd0) |-> (reg_rdata == {30'd0, mode_sh}));

    assert_status_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd1) |-> reg_rdata[0]);

    assert_read_answered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> mem_rvalid);

    assert_no_stray_rvalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> $past(rd_acc));

    assert_wipe_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr == 3'd4 && reg_wdata[0] &&
         mode_sh == 2'd2 && mem_ready) |=> !mem_ready);

    assert_wipe_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && (reg_addr == 3'd4 || reg_addr == 3'd5) &&
         mode_sh != 2'd2 && mem_ready) |=> mem_ready);

    assert_stall_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_cnt <= CNT_W'(MAX_WORDS));

endmodule

bind flash_ctrl flash_ctrl_checker #(
    .MAIN_WORDS (PAGE_WORDS * MAIN_PAGES),
    .CFG_WORDS  (CFG_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid)
);

// File: tb/flash_ctrl_test.sv
module flash_ctrl_test;

    localparam int PW     = 16;
    localparam int NPG    = 8;
    localparam int MW     = PW * NPG;
    localparam int CW     = 32;
    localparam int MBYTES = MW * 4;
    localparam int PBYTES = PW * 4;
    localparam int CBASE  = 32'h8000;
    localparam int CBYTES = CW * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req = 1'b0;
    logic        mem_we = 1'b0;
    logic [15:0] mem_addr = 16'd0;
    logic [31:0] mem_wdata = 32'd0;
    logic        mem_ready;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_main [MW];
    logic [31:0] m_cfg  [CW];
    logic [1:0]  mode_m = 2'd0;

    always #5 clk = ~clk;

    flash_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [15:0] a);
        if (32'(a) < MBYTES) return m_main[a[8:2]];
        if (32'(a) >= CBASE && 32'(a) < CBASE + CBYTES) return m_cfg[5'((32'(a) - CBASE) >> 2)];
        return 32'd0;
    endfunction

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_req = 1'b0; reg_we = 1'b0;
        if (a == 3'd0) mode_m = d[1:0];
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk); d = reg_rdata;
        @(posedge clk); #1;
        reg_req = 1'b0;
    endtask

    task automatic mem_wr(input logic [15:0] a, input logic [31:0] d);
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        while (!mem_ready) @(negedge clk);
        @(posedge clk); #1;
        mem_req = 1'b0; mem_we = 1'b0;
        if (mode_m == 2'd1) begin
            if (32'(a) < MBYTES) m_main[a[8:2]] = d;
            else if (32'(a) >= CBASE && 32'(a) < CBASE + CBYTES) m_cfg[5'((32'(a) - CBASE) >> 2)] = d;
        end
    endtask

    task automatic mem_rd(input logic [15:0] a, output logic [31:0] d, output int st);
        mem_req = 1'b1; mem_we = 1'b0; mem_addr = a; st = 0;
        @(negedge clk);
        while (!mem_ready) begin st++; @(negedge clk); end
        @(posedge clk); #1;
        mem_req = 1'b0;
        @(negedge clk);
        if (!mem_rvalid) begin
            checks++; fails++;
            $display("FAIL R3 rvalid actual=0 expected=1");
        end
        d = mem_rdata;
        @(posedge clk); #1;
    endtask

    task automatic rd_cmp(input string req, input logic [15:0] a);
        logic [31:0] d;
        int st;
        mem_rd(a, d, st);
        chk(req, d, model_rd(a));
    endtask

    task automatic model_erase(input logic [2:0] r, input logic [31:0] d);
        if (mode_m != 2'd2) return;
        if ((r == 3'd2 || r == 3'd3) && d < MBYTES)
            for (int i = 0; i < PW; i++) m_main[(d / PBYTES) * PW + i] = 32'hFFFF_FFFF;
        if (r == 3'd4 && d[0]) for (int i = 0; i < MW; i++) m_main[i] = 32'hFFFF_FFFF;
        if (r == 3'd5 && d[0]) for (int i = 0; i < CW; i++) m_cfg[i] = 32'hFFFF_FFFF;
    endtask

    task automatic erase_and_wait(input string req, input logic [2:0] r, input logic [31:0] d,
                                  input int exp_stall, input logic [15:0] probe);
        logic [31:0] rd;
        int st;
        reg_wr(r, d);
        model_erase(r, d);
        mem_rd(probe, rd, st);
        chk(req, rd, model_rd(probe));
        if (exp_stall >= 0) chk("R9 stall", 32'(st), 32'(exp_stall));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int st;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MW; i++) m_main[i] = 32'd0;
        for (int i = 0; i < CW; i++) m_cfg[i] = 32'd0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // Reset state
        reg_rd(3'd0, d); chk("R1 reset mode", d, 32'd0);
        reg_rd(3'd1, d); chk("R2 status", d & 32'd1, 32'd1);
        chk("R9 ready after reset", 32'(mem_ready), 32'd1);

        // R1 readback of every mode value
        reg_wr(3'd0, 32'd3); reg_rd(3'd0, d); chk("R1 mode3", d, 32'd3);
        reg_wr(3'd0, 32'd1); reg_rd(3'd0, d); chk("R1 mode1", d, 32'd1);
        reg_wr(3'd0, 32'hFFFF_FFFE); reg_rd(3'd0, d); chk("R1 upper bits", d, 32'd2);
        reg_wr(3'd0, 32'd0); reg_rd(3'd0, d); chk("R1 mode0", d, 32'd0);

        // R6 / R7 / R9: whole-region erases and their stall length
        reg_wr(3'd0, 32'd2);
        erase_and_wait("R6 wipe main", 3'd4, 32'd1, MW, 16'd0);
        erase_and_wait("R7 wipe cfg", 3'd5, 32'd1, CW, 16'(CBASE));

        // R3: program every word
        reg_wr(3'd0, 32'd1);
        for (int i = 0; i < MW; i++) mem_wr(16'(i * 4), 32'hA500_0000 + 32'(i));
        for (int i = 0; i < CW; i++) mem_wr(16'(CBASE + i * 4), 32'hC000_0000 + 32'(i));
        rd_cmp("R3 main first", 16'd0);
        rd_cmp("R3 main last", 16'(MBYTES - 4));
        rd_cmp("R3 cfg first", 16'(CBASE));
        rd_cmp("R3 cfg last", 16'(CBASE + CBYTES - 4));

        // R4: writes in other modes ignored
        reg_wr(3'd0, 32'd0); mem_wr(16'h0004, 32'h1111_1111); rd_cmp("R4 mode0", 16'h0004);
        reg_wr(3'd0, 32'd2); mem_wr(16'h0008, 32'h2222_2222); rd_cmp("R4 mode2", 16'h0008);
        reg_wr(3'd0, 32'd3); mem_wr(16'(CBASE + 4), 32'h3333_3333); rd_cmp("R4 mode3", 16'(CBASE + 4));

        // R5: page erase through each register, neighbours intact
        reg_wr(3'd0, 32'd2);
        erase_and_wait("R5 page A", 3'd2, 32'(2 * PBYTES + 20), PW, 16'(2 * PBYTES));
        for (int i = PW; i < 4 * PW; i++) rd_cmp("R5 pages1-3 scan", 16'(i * 4));
        erase_and_wait("R5 page B", 3'd3, 32'(5 * PBYTES + 4), PW, 16'(5 * PBYTES + PBYTES - 4));
        for (int i = 4 * PW; i < 7 * PW; i++) rd_cmp("R5 pages4-6 scan", 16'(i * 4));
        reg_wr(3'd2, 32'(MBYTES));
        chk("R5 out-of-range page ignored", 32'(mem_ready), 32'd1);
        rd_cmp("R7 main kept after cfg wipe", 16'd4);

        // R8: erase writes ignored in wrong mode / bit0 clear / busy
        reg_wr(3'd0, 32'd1); reg_wr(3'd4, 32'd1);
        chk("R8 mode1 wipe ignored", 32'(mem_ready), 32'd1);
        rd_cmp("R8 mode1 data kept", 16'd12);
        reg_wr(3'd0, 32'd0); reg_wr(3'd2, 32'd0); rd_cmp("R8 mode0 page kept", 16'd16);
        reg_wr(3'd0, 32'd3); reg_wr(3'd5, 32'd1); rd_cmp("R8 mode3 cfg kept", 16'(CBASE + 8));
        reg_wr(3'd0, 32'd2); reg_wr(3'd4, 32'd2);
        chk("R8 bit0 clear ignored", 32'(mem_ready), 32'd1);
        rd_cmp("R8 bit0 clear data kept", 16'd20);
        reg_wr(3'd2, 32'd0); model_erase(3'd2, 32'd0);
        reg_wr(3'd5, 32'd1);
        reg_rd(3'd1, d); chk("R2 status during erase", d & 32'd1, 32'd1);
        rd_cmp("R8 busy cfg wipe ignored", 16'(CBASE + 12));
        rd_cmp("R9 stalled read sees erased page", 16'd8);

        // R10: outside both regions
        reg_wr(3'd0, 32'd1);
        mem_wr(16'(MBYTES), 32'hDEAD_BEEF);
        mem_rd(16'(MBYTES), d, st); chk("R10 past main", d, 32'd0);
        mem_wr(16'(CBASE + CBYTES), 32'hDEAD_BEEF);
        mem_rd(16'(CBASE + CBYTES), d, st); chk("R10 past cfg", d, 32'd0);

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [15:0] a;
            op = int'($urandom_range(0, 9));
            case ($urandom_range(0, 5))
                0:       a = 16'(CBASE + 4 * $urandom_range(0, CW));
                1:       a = 16'(MBYTES + 4 * $urandom_range(0, 7));
                default: a = 16'(4 * $urandom_range(0, MW - 1));
            endcase
            if (op == 0) reg_wr(3'd0, 32'($urandom_range(0, 3)));
            else if (op <= 4) mem_wr(a, $urandom);
            else if (op <= 8) rd_cmp("R3 random read", a);
            else begin
                logic [2:0] r;
                logic [31:0] v;
                r = 3'(2 + $urandom_range(0, 3));
                v = (r < 3'd4) ? 32'($urandom_range(0, MBYTES + 255)) : 32'($urandom_range(0, 3));
                erase_and_wait("R5 random erase", r, v, -1, a);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule